// File: doc/BRIEF.md
# Supervisor access control state

This block keeps the small piece of processor state that decides how supervisor-level code may touch pages that belong to user code. It holds the alignment-check flag that the supervisor uses to open a short window for deliberate user-page access, the protection control register, and a one-bit shadow of the supervisor-access-prevention enable. From that state and the current privilege level it derives a 2-bit access-mode index. A translation unit uses that index to pick the permission rules for each access.

Two kinds of event update the state. The first is an instruction strobe that sets or clears the flag. The strobe is honoured only at privilege level 0 and only when the prevention feature exists; otherwise it produces an illegal-opcode pulse. The second is a control-register write. The write strips bits for features that are absent. It asks for a translation-cache flush only when a protection-relevant bit actually changes.

Top module: `sup_access_ctl`

## Requirements
- R1: After reset, `ac_flag`, `cr4_q`, `smap_on`, `tlb_flush` and `ill_op` are all 0, and `mode_idx` is 0 while `priv_lvl` is 0.
- R2: A flag strobe (`acop_valid`=1) at `priv_lvl`=0 with `has_smap`=1 sets `ac_flag` when `acop_set`=1 and clears it when `acop_set`=0. The new value is visible in the cycle after the edge.
- R3: A flag strobe with `has_smap`=0 or `priv_lvl`≠0 leaves `ac_flag` unchanged and raises `ill_op` for exactly one cycle after the edge.
- R4: A write (`cr4_wr_en`=1) stores `cr4_wr_data` into `cr4_q` on the edge, with bit 21 forced to 0 when `has_smap`=0 and bit 9 forced to 0 when `has_sse`=0. All other bits are stored as written.
- R5: On every write, `smap_on` takes bit 21 of the masked value.
- R6: `tlb_flush` is a one-cycle pulse after a write whose masked value differs from the previous `cr4_q` in any of bits 4, 5, 7, 20 or 21. A write that changes no such bit gives no pulse.
- R7: `mode_idx` follows `priv_lvl` in the same cycle. It is 1 when `priv_lvl`=3, 2 when `smap_on`=1 and `ac_flag`=1 at another level, and 0 otherwise. The value 3 never appears.
- R8: A flag strobe and a write in the same cycle both take effect, and `mode_idx` reflects both updates in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| priv_lvl | input | 2 | Current privilege level |
| acop_valid | input | 1 | Flag set/clear instruction strobe |
| acop_set | input | 1 | 1 = set flag, 0 = clear flag |
| cr4_wr_en | input | 1 | Control-register write strobe |
| cr4_wr_data | input | CR_W | New control-register value |
| has_smap | input | 1 | Access-prevention feature present |
| has_sse | input | 1 | Streaming SIMD feature present |
| ac_flag | output | 1 | Alignment-check / access-override flag |
| cr4_q | output | CR_W | Stored control-register value |
| smap_on | output | 1 | Shadow of access-prevention enable |
| tlb_flush | output | 1 | Translation-cache flush pulse |
| ill_op | output | 1 | Illegal-opcode pulse |
| mode_idx | output | 2 | Access-mode index |

## Verification
A wrong flag or enable bit shows up on `mode_idx` in the first cycle after the faulty edge, but only while the privilege level is not 3. At level 3 the index is 1 whatever the state holds, so the stimulus has to spend most cycles at supervisor level. A wrong stored control value shows directly on `cr4_q` one cycle later. A wrong comparison against the old value shows as a missing or extra `tlb_flush` pulse on the following write.

// File: rtl/sup_access_ctl.sv
module sup_access_ctl #(
  parameter int CR_W       = 32,
  parameter int SMAP_BIT   = 21,
  parameter int SMEP_BIT   = 20,
  parameter int OSFXSR_BIT = 9,
  parameter int PGE_BIT    = 7,
  parameter int PAE_BIT    = 5,
  parameter int PSE_BIT    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      priv_lvl,
  input  logic            acop_valid,
  input  logic            acop_set,
  input  logic            cr4_wr_en,
  input  logic [CR_W-1:0] cr4_wr_data,
  input  logic            has_smap,
  input  logic            has_sse,
  output logic            ac_flag,
  output logic [CR_W-1:0] cr4_q,
  output logic            smap_on,
  output logic            tlb_flush,
  output logic            ill_op,
  output logic [1:0]      mode_idx
);
  localparam logic [CR_W-1:0] ONE = CR_W'(1);
  localparam logic [CR_W-1:0] FLUSH_MASK =
    (ONE << PGE_BIT) | (ONE << PAE_BIT) | (ONE << PSE_BIT) |
    (ONE << SMEP_BIT) | (ONE << SMAP_BIT);
  localparam logic [1:0] M_KERN = 2'd0, M_USER = 2'd1, M_KOVR = 2'd2;

  logic            op_ok;
  logic [CR_W-1:0] strip;
  logic [CR_W-1:0] cr4_new;

  assign op_ok   = has_smap && (priv_lvl == 2'd0);
  assign strip   = (has_smap ? '0 : (ONE << SMAP_BIT)) |
                   (has_sse  ? '0 : (ONE << OSFXSR_BIT));
  assign cr4_new = cr4_wr_data & ~strip;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac_flag   <= 1'b0;
      cr4_q     <= '0;
      smap_on   <= 1'b0;
      tlb_flush <= 1'b0;
      ill_op    <= 1'b0;
    end else begin
      ill_op    <= acop_valid && !op_ok;
      tlb_flush <= cr4_wr_en && (((cr4_new ^ cr4_q) & FLUSH_MASK) != '0);
      if (acop_valid && op_ok) ac_flag <= acop_set;
      if (cr4_wr_en) begin
        cr4_q   <= cr4_new;
        smap_on <= cr4_new[SMAP_BIT];
      end
    end
  end

  assign mode_idx = (priv_lvl == 2'd3)   ? M_USER :
                    (smap_on && ac_flag) ? M_KOVR : M_KERN;
endmodule

// File: rtl/sup_access_ctl_chk.sv
module sup_access_ctl_chk #(
  parameter int CR_W     = 32,
  parameter int SMAP_BIT = 21
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      priv_lvl,
  input logic            acop_valid,
  input logic            acop_set,
  input logic            cr4_wr_en,
  input logic            has_smap,
  input logic            ac_flag,
  input logic [CR_W-1:0] cr4_q,
  input logic            smap_on,
  input logic            tlb_flush,
  input logic            ill_op,
  input logic [1:0]      mode_idx
);
  assert_legal_op_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acop_valid && has_smap && priv_lvl == 2'd0) |=> (ac_flag == $past(acop_set)));

  assert_flag_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(acop_valid && has_smap && priv_lvl == 2'd0) |=> $stable(ac_flag));

  assert_ill_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ill_op |-> $past(acop_valid && (!has_smap || priv_lvl != 2'd0)));

  assert_smap_strip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cr4_wr_en && !has_smap) |=> !cr4_q[SMAP_BIT]);

  assert_shadow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cr4_wr_en |=> (smap_on == cr4_q[SMAP_BIT]));

  assert_flush_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_flush |-> $past(cr4_wr_en));

  assert_user_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_lvl == 2'd3) |-> (mode_idx == 2'd1));

  assert_no_mode3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_idx != 2'd3);
endmodule

bind sup_access_ctl sup_access_ctl_chk #(.CR_W(CR_W), .SMAP_BIT(SMAP_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .acop_valid(acop_valid),
  .acop_set(acop_set), .cr4_wr_en(cr4_wr_en), .has_smap(has_smap),
  .ac_flag(ac_flag), .cr4_q(cr4_q), .smap_on(smap_on), .tlb_flush(tlb_flush),
  .ill_op(ill_op), .mode_idx(mode_idx)
);

// File: tb/sup_access_ctl_bench.sv
module sup_access_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  priv_lvl = 2'd0;
  logic        acop_valid = 1'b0, acop_set = 1'b0;
  logic        cr4_wr_en = 1'b0;
  logic [31:0] cr4_wr_data = '0;
  logic        has_smap = 1'b1, has_sse = 1'b1;
  logic        ac_flag, smap_on, tlb_flush, ill_op;
  logic [31:0] cr4_q;
  logic [1:0]  mode_idx;

  int n_cmp = 0, n_bad = 0;
  logic        m_ac, m_smap, m_flush, m_ill;
  logic [31:0] m_cr4;

  always #2 clk = ~clk;

  sup_access_ctl u_sup_access_ctl (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .acop_valid(acop_valid),
    .acop_set(acop_set), .cr4_wr_en(cr4_wr_en), .cr4_wr_data(cr4_wr_data),
    .has_smap(has_smap), .has_sse(has_sse), .ac_flag(ac_flag), .cr4_q(cr4_q),
    .smap_on(smap_on), .tlb_flush(tlb_flush), .ill_op(ill_op), .mode_idx(mode_idx)
  );

  function automatic logic [31:0] masked(logic [31:0] d, logic sm, logic ss);
    logic [31:0] r = d;
    if (!sm) r[21] = 1'b0;
    if (!ss) r[9] = 1'b0;
    return r;
  endfunction

  function automatic logic [1:0] exp_mode(logic [1:0] pl, logic sm, logic ac);
    if (pl == 2'd3) return 2'd1;
    if (sm && ac) return 2'd2;
    return 2'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(string op_req, string cr_req);
    check(op_req, {31'd0, ac_flag}, {31'd0, m_ac});
    check(op_req == "R2" ? "R3" : op_req, {31'd0, ill_op}, {31'd0, m_ill});
    check(cr_req, cr4_q, m_cr4);
    check("R5", {31'd0, smap_on}, {31'd0, m_smap});
    check("R6", {31'd0, tlb_flush}, {31'd0, m_flush});
    check("R7", {30'd0, mode_idx}, {30'd0, exp_mode(priv_lvl, m_smap, m_ac)});
  endtask

  // drive at posedge+1, evaluate model at the edge, sample at next posedge+1
  task automatic step(logic [1:0] pl, logic ov, logic os, logic cw, logic [31:0] cd,
                      logic sm, logic ss, string op_req, string cr_req);
    logic [31:0] nc;
    priv_lvl = pl; acop_valid = ov; acop_set = os;
    cr4_wr_en = cw; cr4_wr_data = cd; has_smap = sm; has_sse = ss;
    @(posedge clk);
    nc = masked(cd, sm, ss);
    m_ill   = ov && !(sm && pl == 2'd0);
    m_flush = cw && (((nc ^ m_cr4) & 32'h0030_00B0) != 0);
    if (ov && sm && pl == 2'd0) m_ac = os;
    if (cw) begin m_cr4 = nc; m_smap = nc[21]; end
    #1;
    check_all(op_req, cr_req);
  endtask

  initial begin : watchdog
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] rv;
    rv = $urandom(32'h5A17_C0DE);
    m_ac = 0; m_smap = 0; m_flush = 0; m_ill = 0; m_cr4 = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    check("R1", {31'd0, ac_flag}, 32'd0);
    check("R1", cr4_q, 32'd0);
    check("R1", {31'd0, smap_on}, 32'd0);
    check("R1", {30'd0, tlb_flush, ill_op}, 32'd0);
    check("R1", {30'd0, mode_idx}, 32'd0);

    // R4/R5/R6 enable prevention: bit21 change flushes
    step(2'd0, 0, 0, 1, 32'h0020_0000, 1, 1, "R2", "R4");
    // R2 legal set -> mode 2
    step(2'd0, 1, 1, 0, 0, 1, 1, "R2", "R4");
    check("R7", {30'd0, mode_idx}, 32'd2);
    // R7 user level overrides
    priv_lvl = 2'd3; #1;
    check("R7", {30'd0, mode_idx}, 32'd1);
    // R3 illegal at level 1: flag stays set
    step(2'd1, 1, 0, 0, 0, 1, 1, "R3", "R4");
    check("R3", {31'd0, ill_op}, 32'd1);
    check("R3", {31'd0, ac_flag}, 32'd1);
    // R3 pulse lasts one cycle
    step(2'd0, 0, 0, 0, 0, 1, 1, "R3", "R4");
    check("R3", {31'd0, ill_op}, 32'd0);
    // R3 illegal at level 0 without feature
    step(2'd0, 1, 0, 0, 0, 0, 1, "R3", "R4");
    check("R3", {31'd0, ac_flag}, 32'd1);
    // R2 legal clear
    step(2'd0, 1, 0, 0, 0, 1, 1, "R2", "R4");
    check("R2", {31'd0, ac_flag}, 32'd0);
    // R6 change only bit 3: no flush; bit 21 kept
    step(2'd0, 0, 0, 1, 32'h0020_0008, 1, 1, "R2", "R6");
    check("R6", {31'd0, tlb_flush}, 32'd0);
    // R4 strip bits 21 and 9 when features absent (bit21 drop -> flush)
    step(2'd0, 0, 0, 1, 32'h0020_0208, 0, 0, "R2", "R4");
    check("R4", cr4_q, 32'h0000_0008);
    check("R6", {31'd0, tlb_flush}, 32'd1);
    // R6 PGE change flushes
    step(2'd0, 0, 0, 1, 32'h0000_0088, 1, 1, "R2", "R6");
    check("R6", {31'd0, tlb_flush}, 32'd1);
    // R8 simultaneous set and enable
    step(2'd0, 1, 1, 1, 32'h0020_0088, 1, 1, "R8", "R8");
    check("R8", {30'd0, mode_idx}, 32'd2);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] d;
      logic [1:0]  pl;
      d  = $urandom() & 32'h0030_02BF;
      pl = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
      step(pl, ($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 3) == 0), d,
           ($urandom_range(0, 7) != 0), ($urandom_range(0, 3) != 0), "R2", "R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule